// File: doc/BRIEF.md
# Terminal Address Latch with Parity Check

This block holds the five-bit address of a serial-bus remote terminal together with its parity bit, and decides whether the terminal may answer a command. The address can come from strap pins or from a word written by the host. A latch-control pin picks how it is held. With the pin low, the held value tracks the pins. When the pin rises, the held value is frozen at the pin values present at that edge. With the pin held high, only the host can load a new value, and it must first step a small arming state machine through two configuration writes.

The latch-control pin and the strap pins pass through a two-stage synchronizer. Every capture uses the synchronized copies. The arming machine has three states. `ST_IDLE` is disarmed. `ST_ENH` means the enhanced-mode bit is set. `ST_ARMED` means the latch-enable bit is also set. Its transitions are:
- `ST_IDLE` to `ST_ENH` on a mode write with bit 15 set.
- `ST_ENH` to `ST_ARMED` on a control write with bit 3 set.
- `ST_ARMED` to `ST_ENH` on a control write with bit 3 clear.
- `ST_ENH` or `ST_ARMED` to `ST_IDLE` on a mode write with bit 15 clear.

Every other write leaves the state as it is. A write to the address register while the machine is in `ST_ARMED` and the latch pin is held high loads the held value.

The six held bits must contain an odd number of ones for the terminal to answer non-broadcast commands. Broadcast commands are answered whatever the parity.

Top module: `term_addr_latch`

## Requirements
- R1: During and after reset, the outputs `addr_q`, `par_q` and `par_ok` are 0, the arming machine is in `ST_IDLE` and the source select is 0.
- R2: While the synchronized latch pin is 0, `addr_q` and `par_q` follow `addr_pin` and `par_pin` with a latency of three clock edges (two synchronizer stages plus the holding register).
- R3: On a synchronized 0-to-1 transition of `latch_pin`, the synchronized pin values at that edge are captured. While the pin then stays high and the host loads nothing, later changes on the pins do not change `addr_q` or `par_q`.
- R4: With the latch pin held high, a pulse on `wr_addr` loads a new value only in `ST_ARMED`. That state is reached by a `wr_mode` write with bit 15 = 1 followed by a `wr_ctl` write with bit 3 = 1. A `wr_ctl` write in `ST_IDLE` is ignored, and so is a `wr_addr` pulse in `ST_IDLE` or `ST_ENH`.
- R5: With source select = 1, a loading `wr_addr` write takes the address from `host_data[5:1]` (bit 5 is the MSB) and the parity from `host_data[0]`.
- R6: With source select = 0, a loading `wr_addr` write ignores `host_data[5:0]` and captures the synchronized pin values.
- R7: `par_ok` is 1 exactly when `{addr_q, par_q}` has an odd number of ones.
- R8: `resp_en` equals `bcast | par_ok`, with no added latency.
- R9: In `ST_ARMED`, a `wr_ctl` write with bit 3 = 0 returns the machine to `ST_ENH`. In `ST_ENH` or `ST_ARMED`, a `wr_mode` write with bit 15 = 0 returns it to `ST_IDLE`. After either write, `wr_addr` no longer loads.
- R10: A `wr_src` write sets the source select to `host_data[5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_pin | input | 5 | Strap address pins |
| par_pin | input | 1 | Strap parity pin |
| latch_pin | input | 1 | Latch-control pin |
| host_data | input | 16 | Host write data |
| wr_mode | input | 1 | Write strobe for the mode register (enhanced bit 15) |
| wr_ctl | input | 1 | Write strobe for the control register (latch-enable bit 3) |
| wr_addr | input | 1 | Write strobe for the address register |
| wr_src | input | 1 | Write strobe for the source-select register (bit 5) |
| bcast | input | 1 | Current command is a broadcast |
| addr_q | output | 5 | Held terminal address |
| par_q | output | 1 | Held parity bit |
| par_ok | output | 1 | Odd parity over the held six bits |
| resp_en | output | 1 | Terminal may respond |

## Verification
The bench changes the pins after a rising latch edge. A design that kept tracking the pins, or that captured the raw pins instead of the synchronized ones, would then show values at the wrong cycle or drift. It attempts address loads out of order: before arming, after a premature control write, and after each disarming write. A state machine that accepted a shortcut would load a value where the reference holds. With source select 0, it loads host data whose low bits differ from the pins, which exposes a design that takes the bus when it should not. Even-parity addresses are paired with broadcast on and off to catch a response gate that ignores either term.

// File: rtl/tal_pkg.sv
package tal_pkg;
    localparam int ADDR_W = 5;
    localparam int HELD_W = ADDR_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENH   = 2'd1,
        ST_ARMED = 2'd2
    } host_st_t;
endpackage

// File: rtl/tal_sync.sv
module tal_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/tal_host_fsm.sv
module tal_host_fsm
    import tal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic mode_val,
    input  logic wr_ctl,
    input  logic ctl_val,
    output logic armed
);
    host_st_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_mode && mode_val) state_nx = ST_ENH;
            end
            ST_ENH: begin
                if (wr_mode && !mode_val)     state_nx = ST_IDLE;
                else if (wr_ctl && ctl_val)   state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (wr_mode && !mode_val)     state_nx = ST_IDLE;
                else if (wr_ctl && !ctl_val)  state_nx = ST_ENH;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        armed = (state == ST_ARMED);
    end

    // R4
    armed_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> ($past(state) != ST_IDLE));

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && !mode_val) |=> (state == ST_IDLE));
endmodule

// File: rtl/tal_parity.sv
module tal_parity #(
    parameter int W = 6
) (
    input  logic [W-1:0] bits,
    output logic         odd
);
    always_comb begin
        odd = ^bits;
    end
endmodule

// File: rtl/term_addr_latch.sv
module term_addr_latch
    import tal_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MODE_BIT = 15,
    parameter int CTL_BIT  = 3,
    parameter int SRC_BIT  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_pin,
    input  logic              par_pin,
    input  logic              latch_pin,
    input  logic [DATA_W-1:0] host_data,
    input  logic              wr_mode,
    input  logic              wr_ctl,
    input  logic              wr_addr,
    input  logic              wr_src,
    input  logic              bcast,
    output logic [ADDR_W-1:0] addr_q,
    output logic              par_q,
    output logic              par_ok,
    output logic              resp_en
);
    localparam int SYNC_W = HELD_W + 1;

    logic [SYNC_W-1:0] pins_s;
    logic [HELD_W-1:0] pin_word;
    logic              lat_s;
    logic              lat_d;
    logic              src_sel;
    logic              armed;
    logic [HELD_W-1:0] held_q;
    logic [HELD_W-1:0] held_nx;
    logic              load;

    tal_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({latch_pin, par_pin, addr_pin}),
        .q     (pins_s)
    );

    assign lat_s    = pins_s[SYNC_W-1];
    assign pin_word = {pins_s[ADDR_W-1:0], pins_s[ADDR_W]};

    tal_host_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (wr_mode),
        .mode_val (host_data[MODE_BIT]),
        .wr_ctl   (wr_ctl),
        .ctl_val  (host_data[CTL_BIT]),
        .armed    (armed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_d   <= 1'b0;
            src_sel <= 1'b0;
        end else begin
            lat_d <= lat_s;
            if (wr_src) src_sel <= host_data[SRC_BIT];
        end
    end

    always_comb begin
        load    = 1'b0;
        held_nx = pin_word;
        if (!lat_s || !lat_d) begin
            load = 1'b1;
        end else if (wr_addr && armed) begin
            load = 1'b1;
            if (src_sel) held_nx = host_data[HELD_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    held_q <= '0;
        else if (load) held_q <= held_nx;
    end

    assign addr_q = held_q[HELD_W-1:1];
    assign par_q  = held_q[0];

    tal_parity #(.W(HELD_W)) u_par (
        .bits (held_q),
        .odd  (par_ok)
    );

    assign resp_en = bcast | par_ok;

    // R2
    transparent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_s |=> ({addr_q, par_q} == $past(pin_word)));

    // R3
    rise_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_s && !lat_d) |=> ({addr_q, par_q} == $past(pin_word)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_s && lat_d && !wr_addr) |=> $stable({addr_q, par_q}));

    // R8
    bcast_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcast |-> resp_en);
endmodule

// File: tb/term_addr_latch_bench.sv
module term_addr_latch_bench;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr_pin = '0;
    logic        par_pin = 1'b0;
    logic        latch_pin = 1'b0;
    logic [15:0] host_data = '0;
    logic        wr_mode = 1'b0, wr_ctl = 1'b0, wr_addr = 1'b0, wr_src = 1'b0;
    logic        bcast = 1'b0;
    logic [4:0]  addr_q;
    logic        par_q, par_ok, resp_en;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    done   = 1'b0;

    logic [6:0] hist[$];
    logic [4:0] m_addr = '0;
    logic       m_par = 1'b0;
    bit         m_mode = 0, m_arm = 0, m_src = 0;

    term_addr_latch u_term_addr_latch (
        .clk(clk), .rst_n(rst_n), .addr_pin(addr_pin), .par_pin(par_pin),
        .latch_pin(latch_pin), .host_data(host_data), .wr_mode(wr_mode),
        .wr_ctl(wr_ctl), .wr_addr(wr_addr), .wr_src(wr_src), .bcast(bcast),
        .addr_q(addr_q), .par_q(par_q), .par_ok(par_ok), .resp_en(resp_en)
    );

    always #(PER/2) clk = ~clk;

    function automatic bit odd6(input logic [4:0] a, input logic p);
        int n = 0;
        for (int i = 0; i < 5; i++) if (a[i]) n++;
        if (p) n++;
        return (n % 2) == 1;
    endfunction

    // behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{7'd0, 7'd0, 7'd0};
            m_addr = '0; m_par = 0; m_mode = 0; m_arm = 0; m_src = 0;
        end else begin
            logic [6:0] s2;
            bit lat_now, lat_old;
            s2 = hist[1];
            lat_now = s2[6];
            lat_old = hist[2][6];
            if (!lat_now || !lat_old) begin
                m_addr = s2[4:0]; m_par = s2[5];
            end else if (wr_addr && m_mode && m_arm) begin
                if (m_src) begin m_addr = host_data[5:1]; m_par = host_data[0]; end
                else       begin m_addr = s2[4:0];        m_par = s2[5];        end
            end
            if (wr_mode) begin
                if (!host_data[15]) m_arm = 0;
                m_mode = host_data[15];
            end else if (wr_ctl) begin
                m_arm = m_mode && host_data[3];
            end
            if (wr_src) m_src = host_data[5];
            hist.push_front({latch_pin, par_pin, addr_pin});
            void'(hist.pop_back());
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // compare on every clock, away from the edge
    always @(posedge clk) begin
        #(PER/4);
        if (rst_n && !done) begin
            bit ok;
            ok = odd6(m_addr, m_par);
            check(phase, "addr_q", addr_q, m_addr);
            check(phase, "par_q", par_q, m_par);
            check("R7", "par_ok", par_ok, ok);
            check("R8", "resp_en", resp_en, ok | bcast);
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pins(logic [4:0] a, logic p);
        addr_pin = a; par_pin = p;
    endtask

    task automatic wr(int which, logic [15:0] d);
        @(negedge clk);
        host_data = d;
        wr_mode = (which == 3); wr_ctl = (which == 4);
        wr_addr = (which == 5); wr_src = (which == 6);
        @(negedge clk);
        wr_mode = 0; wr_ctl = 0; wr_addr = 0; wr_src = 0;
        host_data = 16'h0000;
    endtask

    initial begin
        #(PER*150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pins(5'h1f, 1'b1);
        step(3);
        // R1: reset values held while reset is asserted
        check("R1", "addr_q in reset", addr_q, 0);
        check("R1", "par_q in reset", par_q, 0);
        check("R1", "par_ok in reset", par_ok, 0);
        rst_n = 1'b1;
        pins(5'h00, 1'b0);
        step(1);
        check("R1", "addr_q after reset", addr_q, 0);

        phase = "R2";
        pins(5'h15, 1'b0); step(2);
        check("R2", "not yet visible", addr_q, 0);
        step(2);
        check("R2", "visible after latency", addr_q, 5'h15);
        pins(5'h0a, 1'b1); step(4);
        pins(5'h03, 1'b0); bcast = 1; step(4);
        bcast = 0; step(2);
        pins(5'h03, 1'b1); step(4);

        phase = "R3";
        pins(5'h12, 1'b1); step(4);
        latch_pin = 1; step(4);
        pins(5'h07, 1'b0); step(6);
        check("R3", "held after rise", addr_q, 5'h12);

        phase = "R4";
        wr(5, 16'h0000); step(3);
        wr(4, 16'h0008); wr(5, 16'h0000); step(3);
        check("R4", "no load before arming", addr_q, 5'h12);
        wr(3, 16'h8000); wr(5, 16'h0000); step(3);
        check("R4", "no load in enhanced only", addr_q, 5'h12);
        wr(4, 16'h0008); wr(5, 16'h003f); step(3);
        check("R4", "armed load from pins", addr_q, 5'h07);

        phase = "R10";
        wr(6, 16'h0020); step(2);
        phase = "R5";
        wr(5, 16'h002c); step(3);
        check("R5", "host address", addr_q, 5'h16);
        check("R5", "host parity", par_q, 0);
        wr(5, 16'h0015); step(3);
        bcast = 1; step(2); bcast = 0;

        phase = "R9";
        wr(4, 16'h0000); wr(5, 16'h003f); step(3);
        check("R9", "no load after ctl clear", addr_q, 5'h0a);
        wr(4, 16'h0008); wr(3, 16'h0000); wr(5, 16'h0001); step(3);
        check("R9", "no load after mode clear", addr_q, 5'h0a);

        phase = "R6";
        wr(6, 16'h0000);
        wr(3, 16'h8000); wr(4, 16'h0008);
        pins(5'h19, 1'b1); step(3);
        wr(5, 16'h002a); step(3);
        check("R6", "pins latched not bus", addr_q, 5'h19);
        check("R6", "pin parity latched", par_q, 1);

        phase = "R2";
        latch_pin = 0; pins(5'h04, 1'b0); step(5);
        check("R2", "transparent again", addr_q, 5'h04);
        step(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule